// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block sequences the transmission of an in-frame response on a J1850-style multiplex bus. It sits between software-facing controls and a bit-level transmitter. Software loads a data register and arms one of two response kinds: a single byte with no CRC, or a run of bytes closed by a CRC byte and an end-of-data symbol. When the bus delivers a valid end-of-data symbol, the sequencer asks the transmitter for a normalization bit. It then hands over bytes for shifting and reacts to arbitration loss, bus errors and transmitter completion.

The block works at byte and symbol level only. A normalization-bit request and an end-of-data-symbol request are held high until the transmitter reports the symbol done. A byte hand-off is a one-cycle load strobe with the byte on a parallel bus. Bit timing, symbol encoding and bitwise arbitration belong to the transmitter behind it.

Top module: `ifr_tx_seq`

## Requirements
- R1: A response starts only when `eod_rx_i` arrives with `crc_err_i` low while a request bit is set. An end-of-data symbol flagged with a CRC error starts nothing and leaves the armed request bit set.
- R2: A request set in the same cycle as `eod_rx_i`, or within GUARD_CYC cycles after it, is dropped and its request bit stays 0.
- R3: A started response first raises `norm_bit_o` and holds it until `sym_done_i`. Only then does the first `load_o` strobe present the data register on `tx_byte_o`.
- R4: In single-byte mode, `tx_done_i` for the loaded byte clears `resp_single_o` and ends the response without a CRC byte.
- R5: In single-byte mode, `arb_lost_i` during a byte suspends loading with no normalization bit and no filler bits. After `rx_done_i` marks the end of the winning byte, the same byte is loaded again with no normalization bit.
- R6: Setting `resp_end_i` clears `resp_single_o`. A single-byte request cleared this way is not transmitted at the next end-of-data symbol.
- R7: In CRC mode, each data-byte load raises `dr_empty_o` unless an end request is already pending. A data register write or `resp_end_i` clears it.
- R8: In CRC mode with an end request pending, the order is fixed. The last data byte completes, the CRC byte is loaded, then `eod_tx_o` is raised until `sym_done_i`, after which `resp_crc_o` clears.
- R9: In CRC mode, `tx_done_i` with no data register write since the last load, and no end request, is an underrun. It clears `resp_crc_o` and `dr_empty_o` and loads nothing more. A write in the same cycle as `tx_done_i` counts as in time, and the new byte is loaded.
- R10: When `resp_end_i` answers the first `dr_empty_o`, exactly one data byte precedes the CRC byte and `dr_empty_o` is not raised again.
- R11: The CRC byte is the bitwise inverse of a CRC-8 over the response data bytes only. The CRC-8 uses polynomial 0x1D (x^8+x^4+x^3+x^2+1), starts from 0xFF and runs MSB first.
- R12: `bus_err_i` returns the sequencer to idle in the next cycle and clears both request bits and `dr_empty_o`.
- R13: Reset clears both request bits and all flags. Setting both requests in one cycle arms only CRC mode. A single-byte request is refused while CRC mode is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_wr_i | input | 1 | Write strobe for the data register |
| data_i | input | 8 | Data register write value |
| resp_single_set_i | input | 1 | Arm single-byte response without CRC |
| resp_crc_set_i | input | 1 | Arm multi-byte response with CRC |
| resp_end_i | input | 1 | End request: last byte supplied |
| resp_single_o | output | 1 | Single-byte request bit |
| resp_crc_o | output | 1 | CRC-mode request bit |
| dr_empty_o | output | 1 | Data register moved to shifter, next byte wanted |
| eod_rx_i | input | 1 | End-of-data symbol received from bus |
| crc_err_i | input | 1 | Received frame failed its CRC (qualifies eod_rx_i) |
| sym_done_i | input | 1 | Requested normalization bit or EOD symbol finished |
| tx_done_i | input | 1 | Loaded byte fully transmitted |
| arb_lost_i | input | 1 | Arbitration lost on the current byte |
| rx_done_i | input | 1 | Byte of the winning node finished on the bus |
| bus_err_i | input | 1 | Bus error detected |
| norm_bit_o | output | 1 | Request a normalization bit |
| load_o | output | 1 | One-cycle strobe: load tx_byte_o into the shifter |
| tx_byte_o | output | 8 | Byte to load (data register or CRC) |
| eod_tx_o | output | 1 | Request an end-of-data symbol |

## Verification
Two events can coincide with a byte finishing: a data register write and the transmitter's completion. A write arriving in the same cycle as `tx_done_i` must count as a refill, not an underrun. The bench drives both strobes in one cycle and expects the next `load_o` to carry the new byte. A request set in the very cycle an end-of-data symbol arrives must lose. The bench raises both together and expects the request bit to stay at 0. It then confirms that a later set, after the guard window, does arm.

// File: rtl/ifr_pkg.sv
`timescale 1ns/1ps
package ifr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NORM, ST_LDAT, ST_SEND, ST_ARBW, ST_LCRC, ST_SCRC, ST_EODS
  } ifr_state_e;

  function automatic logic [BYTE_W-1:0] crc8_step(input logic [BYTE_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d,
                                                  input logic [BYTE_W-1:0] poly);
    logic [BYTE_W-1:0] r;
    r = c ^ d;
    for (int i = 0; i < BYTE_W; i++) r = r[BYTE_W-1] ? ((r << 1) ^ poly) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/ifr_crc8.sv
`timescale 1ns/1ps
module ifr_crc8 import ifr_pkg::*; #(
  parameter logic [BYTE_W-1:0] POLY = 8'h1D,
  parameter logic [BYTE_W-1:0] SEED = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] crc_o
);
  logic [BYTE_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= SEED;
    else if (init_i) crc_q <= SEED;
    else if (upd_i)  crc_q <= crc8_step(crc_q, data_i, POLY);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/ifr_req_ctrl.sv
`timescale 1ns/1ps
module ifr_req_ctrl #(
  parameter int GUARD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_s_i,
  input  logic set_m_i,
  input  logic end_i,
  input  logic eod_rx_i,
  input  logic idle_i,
  input  logic clr_s_i,
  input  logic clr_m_i,
  input  logic clr_all_i,
  output logic req_s_o,
  output logic req_m_o
);
  localparam int GW = $clog2(GUARD_CYC + 1);

  logic [GW-1:0] guard_q;
  logic          req_s_q, req_m_q, accept;

  assign accept = idle_i && (guard_q == '0) && !eod_rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             guard_q <= '0;
    else if (eod_rx_i)       guard_q <= GW'(GUARD_CYC);
    else if (guard_q != '0)  guard_q <= guard_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_s_q <= 1'b0;
      req_m_q <= 1'b0;
    end else begin
      if (clr_all_i || clr_m_i)     req_m_q <= 1'b0;
      else if (accept && set_m_i)   req_m_q <= 1'b1;

      if (clr_all_i || clr_s_i || end_i || (accept && set_m_i)) req_s_q <= 1'b0;
      else if (accept && set_s_i && !req_m_q)                   req_s_q <= 1'b1;
    end
  end

  assign req_s_o = req_s_q;
  assign req_m_o = req_m_q;

  AST_NO_LATE_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eod_rx_i && !req_s_q && !req_m_q) |=> (!req_s_q && !req_m_q)); // R2
  AST_ARM_AFTER_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_s_q) |-> ($past(guard_q) == '0)); // R2
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_s_q && req_m_q)); // R13
endmodule

// File: rtl/ifr_tx_fsm.sv
`timescale 1ns/1ps
module ifr_tx_fsm import ifr_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic req_m_i,
  input  logic data_wr_i,
  input  logic end_i,
  input  logic eod_rx_i,
  input  logic crc_err_i,
  input  logic sym_done_i,
  input  logic tx_done_i,
  input  logic arb_lost_i,
  input  logic rx_done_i,
  input  logic bus_err_i,
  output logic idle_o,
  output logic clr_s_o,
  output logic clr_m_o,
  output logic clr_all_o,
  output logic crc_init_o,
  output logic crc_upd_o,
  output logic sel_crc_o,
  output logic dr_empty_o,
  output logic norm_bit_o,
  output logic load_o,
  output logic eod_tx_o
);
  ifr_state_e state, nxt;
  logic mode_m, eod_pend, dr_full, tdre_q, ending, active;

  assign active = mode_m ? req_m_i : req_s_i;

  always_comb begin
    nxt        = state;
    clr_s_o    = 1'b0;
    clr_m_o    = 1'b0;
    crc_init_o = 1'b0;
    unique case (state)
      ST_IDLE: if (eod_rx_i && !crc_err_i && (req_s_i || req_m_i)) begin
        nxt        = ST_NORM;
        crc_init_o = 1'b1;
      end
      ST_NORM: if (sym_done_i) nxt = active ? ST_LDAT : ST_IDLE;
      ST_LDAT: nxt = ST_SEND;
      ST_SEND: begin
        if (arb_lost_i) begin
          if (mode_m) begin clr_m_o = 1'b1; nxt = ST_IDLE; end
          else nxt = ST_ARBW;
        end else if (tx_done_i) begin
          if (!mode_m) begin clr_s_o = 1'b1; nxt = ST_IDLE; end
          else if (dr_full || data_wr_i) nxt = ST_LDAT;
          else if (eod_pend || end_i)    nxt = ST_LCRC;
          else begin clr_m_o = 1'b1; nxt = ST_IDLE; end  // underrun
        end
      end
      ST_ARBW: if (rx_done_i) nxt = req_s_i ? ST_LDAT : ST_IDLE;
      ST_LCRC: nxt = ST_SCRC;
      ST_SCRC: begin
        if (arb_lost_i) begin clr_m_o = 1'b1; nxt = ST_IDLE; end
        else if (tx_done_i) nxt = ST_EODS;
      end
      ST_EODS: if (sym_done_i) begin clr_m_o = 1'b1; nxt = ST_IDLE; end
      default: nxt = ST_IDLE;
    endcase
    if (bus_err_i) nxt = ST_IDLE;
  end

  assign clr_all_o = bus_err_i;
  assign ending    = (state != ST_IDLE) && (nxt == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      mode_m   <= 1'b0;
      eod_pend <= 1'b0;
      dr_full  <= 1'b0;
      tdre_q   <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && nxt == ST_NORM) mode_m <= req_m_i;

      if (bus_err_i || ending) eod_pend <= 1'b0;
      else if (end_i && ((state != ST_IDLE) ? mode_m : req_m_i)) eod_pend <= 1'b1;

      if (data_wr_i)               dr_full <= 1'b1;
      else if (state == ST_LDAT)   dr_full <= 1'b0;

      if (bus_err_i || ending || data_wr_i || end_i)       tdre_q <= 1'b0;
      else if (state == ST_LDAT && mode_m && !eod_pend)    tdre_q <= 1'b1;
    end
  end

  assign idle_o     = (state == ST_IDLE);
  assign crc_upd_o  = (state == ST_LDAT) && mode_m;
  assign sel_crc_o  = (state == ST_LCRC);
  assign load_o     = (state == ST_LDAT) || (state == ST_LCRC);
  assign norm_bit_o = (state == ST_NORM);
  assign eod_tx_o   = (state == ST_EODS);
  assign dr_empty_o = tdre_q;

  AST_LOAD_AFTER_NORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LDAT) |-> ($past(state) == ST_NORM || $past(state) == ST_SEND ||
                            $past(state) == ST_ARBW)); // R3
  AST_ARB_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SEND && arb_lost_i && !bus_err_i && !mode_m) |=> (state == ST_ARBW)); // R5
  AST_TDRE_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LDAT && mode_m && !eod_pend && !data_wr_i && !end_i && !bus_err_i)
      |=> tdre_q); // R7
  AST_EOD_AFTER_CRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EODS) |-> ($past(state) == ST_SCRC || $past(state) == ST_EODS)); // R8
  AST_BUS_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_i |=> (state == ST_IDLE && !tdre_q)); // R12
endmodule

// File: rtl/ifr_tx_seq.sv
`timescale 1ns/1ps
module ifr_tx_seq import ifr_pkg::*; #(
  parameter int                GUARD_CYC = 4,
  parameter logic [BYTE_W-1:0] CRC_POLY  = 8'h1D,
  parameter logic [BYTE_W-1:0] CRC_SEED  = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_wr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              resp_single_set_i,
  input  logic              resp_crc_set_i,
  input  logic              resp_end_i,
  output logic              resp_single_o,
  output logic              resp_crc_o,
  output logic              dr_empty_o,
  input  logic              eod_rx_i,
  input  logic              crc_err_i,
  input  logic              sym_done_i,
  input  logic              tx_done_i,
  input  logic              arb_lost_i,
  input  logic              rx_done_i,
  input  logic              bus_err_i,
  output logic              norm_bit_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              eod_tx_o
);
  logic [BYTE_W-1:0] dr_q, crc;
  logic idle, clr_s, clr_m, clr_all, crc_init, crc_upd, sel_crc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dr_q <= '0;
    else if (data_wr_i) dr_q <= data_i;
  end

  ifr_req_ctrl #(.GUARD_CYC(GUARD_CYC)) u_req (
    .clk_i, .rst_ni,
    .set_s_i  (resp_single_set_i),
    .set_m_i  (resp_crc_set_i),
    .end_i    (resp_end_i),
    .eod_rx_i,
    .idle_i   (idle),
    .clr_s_i  (clr_s),
    .clr_m_i  (clr_m),
    .clr_all_i(clr_all),
    .req_s_o  (resp_single_o),
    .req_m_o  (resp_crc_o)
  );

  ifr_tx_fsm u_fsm (
    .clk_i, .rst_ni,
    .req_s_i   (resp_single_o),
    .req_m_i   (resp_crc_o),
    .data_wr_i,
    .end_i     (resp_end_i),
    .eod_rx_i, .crc_err_i, .sym_done_i, .tx_done_i, .arb_lost_i, .rx_done_i, .bus_err_i,
    .idle_o    (idle),
    .clr_s_o   (clr_s),
    .clr_m_o   (clr_m),
    .clr_all_o (clr_all),
    .crc_init_o(crc_init),
    .crc_upd_o (crc_upd),
    .sel_crc_o (sel_crc),
    .dr_empty_o,
    .norm_bit_o,
    .load_o,
    .eod_tx_o
  );

  ifr_crc8 #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk_i, .rst_ni,
    .init_i(crc_init),
    .upd_i (crc_upd),
    .data_i(dr_q),
    .crc_o (crc)
  );

  assign tx_byte_o = sel_crc ? ~crc : dr_q;
endmodule

// File: tb/ifr_tx_seq_test.sv
`timescale 1ns/1ps
module ifr_tx_seq_test;
  localparam int GUARD_CYC = 4;
  localparam int P_SYM = 0, P_TX = 1, P_ARB = 2, P_RX = 3, P_ERR = 4, P_END = 5,
                 P_EOD = 6, P_SETS = 7, P_SETM = 8, P_EODX = 9;
  localparam int NV = 6;
  // {crc_mode, byte0, byte1}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'h12, 8'h34}, {1'b0, 8'hA5, 8'h00}, {1'b1, 8'h00, 8'hFF},
    {1'b1, 8'hFF, 8'h00}, {1'b0, 8'h3C, 8'h00}, {1'b1, 8'h80, 8'h01}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic data_wr = 0, set_s = 0, set_m = 0, rend = 0, eod_rx = 0, crc_err = 0;
  logic sym_done = 0, tx_done = 0, arb_lost = 0, rx_done = 0, bus_err = 0;
  logic [7:0] data = 8'h00;
  logic req_s, req_m, dr_empty, norm_bit, load, eod_tx;
  logic [7:0] tx_byte;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ifr_tx_seq #(.GUARD_CYC(GUARD_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_wr_i(data_wr), .data_i(data),
    .resp_single_set_i(set_s), .resp_crc_set_i(set_m), .resp_end_i(rend),
    .resp_single_o(req_s), .resp_crc_o(req_m), .dr_empty_o(dr_empty),
    .eod_rx_i(eod_rx), .crc_err_i(crc_err), .sym_done_i(sym_done), .tx_done_i(tx_done),
    .arb_lost_i(arb_lost), .rx_done_i(rx_done), .bus_err_i(bus_err),
    .norm_bit_o(norm_bit), .load_o(load), .tx_byte_o(tx_byte), .eod_tx_o(eod_tx)
  );

  function automatic logic [7:0] ref_crc(input logic [7:0] a, input logic [7:0] b, input bit two);
    logic [7:0] c;
    c = 8'hFF;
    for (int k = 0; k < (two ? 2 : 1); k++) begin
      c ^= (k == 0) ? a : b;
      for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
    end
    return ~c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic pulse(input int k);
    case (k)
      P_SYM:  sym_done = 1;
      P_TX:   tx_done  = 1;
      P_ARB:  arb_lost = 1;
      P_RX:   rx_done  = 1;
      P_ERR:  bus_err  = 1;
      P_END:  rend     = 1;
      P_EOD:  eod_rx   = 1;
      P_SETS: set_s    = 1;
      P_SETM: set_m    = 1;
      P_EODX: begin eod_rx = 1; crc_err = 1; end
      default: ;
    endcase
    tick;
    {sym_done, tx_done, arb_lost, rx_done, bus_err, rend, eod_rx, set_s, set_m, crc_err} = '0;
  endtask

  task automatic wr(input logic [7:0] b);
    data = b; data_wr = 1; tick; data_wr = 0;
  endtask

  task automatic settle;
    repeat (GUARD_CYC + 2) tick;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary;
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    // R13 reset state
    chk("R13 reset req", {req_s, req_m}, 2'b00);
    chk("R13 reset flags", {dr_empty, norm_bit, load, eod_tx}, 4'b0000);
    rst_n = 1; tick;

    // vector walk
    for (int v = 0; v < NV; v++) begin
      settle;
      wr(VEC[v][15:8]);
      pulse(VEC[v][16] ? P_SETM : P_SETS);
      pulse(P_EOD);
      chk("R3 norm bit first", {norm_bit, load}, 2'b10);
      pulse(P_SYM);
      chk("R3 first load", {load, tx_byte}, {1'b1, VEC[v][15:8]});
      tick;
      if (VEC[v][16]) begin
        chk("R7 empty on load", dr_empty, 1'b1);
        wr(VEC[v][7:0]);
        chk("R7 write clears empty", dr_empty, 1'b0);
        pulse(P_END);
        pulse(P_TX);
        chk("R8 second data load", {load, tx_byte}, {1'b1, VEC[v][7:0]});
        tick;
        chk("R7 no empty when end pending", dr_empty, 1'b0);
        pulse(P_TX);
        chk("R11 crc byte", {load, tx_byte}, {1'b1, ref_crc(VEC[v][15:8], VEC[v][7:0], 1'b1)});
        tick;
        pulse(P_TX);
        chk("R8 eod symbol after crc", {eod_tx, load}, 2'b10);
        pulse(P_SYM);
        chk("R8 crc request cleared", {req_m, eod_tx}, 2'b00);
      end else begin
        pulse(P_TX);
        chk("R4 single done", {req_s, load}, 2'b00);
        tick;
        chk("R4 no crc after single", {load, norm_bit, eod_tx}, 3'b000);
      end
    end

    // R2: set in the EOD cycle and inside the guard window is dropped
    settle;
    eod_rx = 1; set_s = 1; tick; eod_rx = 0; set_s = 0;
    chk("R2 set with eod dropped", req_s, 1'b0);
    pulse(P_SETS);
    chk("R2 set in guard dropped", req_s, 1'b0);
    settle;
    pulse(P_SETS);
    chk("R2 set after guard arms", req_s, 1'b1);

    // R1: EOD with CRC error starts nothing
    settle;
    pulse(P_EODX);
    chk("R1 crc-error eod no start", norm_bit, 1'b0);
    chk("R1 request kept", req_s, 1'b1);
    pulse(P_EOD);
    chk("R1 valid eod starts", norm_bit, 1'b1);
    pulse(P_ERR);
    chk("R12 bus error clears", {req_s, norm_bit}, 2'b00);

    // R5: arbitration loss and retry without normalization bit
    settle;
    wr(8'h5A);
    pulse(P_SETS);
    pulse(P_EOD);
    pulse(P_SYM);
    tick;
    pulse(P_ARB);
    for (int i = 0; i < 3; i++) begin
      chk("R5 quiet while winner sends", {load, norm_bit}, 2'b00);
      tick;
    end
    pulse(P_RX);
    chk("R5 retry load no norm", {load, norm_bit, tx_byte}, {2'b10, 8'h5A});
    tick;
    pulse(P_TX);
    chk("R5 retry success clears", req_s, 1'b0);

    // R6: end request clears single request
    settle;
    pulse(P_SETS);
    pulse(P_END);
    chk("R6 end clears single", req_s, 1'b0);
    pulse(P_EOD);
    chk("R6 no response", norm_bit, 1'b0);

    // R9: underrun
    settle;
    wr(8'h11);
    pulse(P_SETM);
    pulse(P_EOD);
    pulse(P_SYM);
    tick;
    pulse(P_TX);
    chk("R9 underrun clears", {req_m, dr_empty, load}, 3'b000);

    // R9: write in the same cycle as tx_done refills
    settle;
    wr(8'h22);
    pulse(P_SETM);
    pulse(P_EOD);
    pulse(P_SYM);
    tick;
    data = 8'h33; data_wr = 1; tx_done = 1; tick; data_wr = 0; tx_done = 0;
    chk("R9 same-cycle write loads", {load, tx_byte}, {1'b1, 8'h33});
    tick;
    pulse(P_ERR);
    chk("R12 bus error mid response", {req_m, dr_empty, load, eod_tx}, 4'b0000);

    // R10: end answering first empty flag
    settle;
    wr(8'hC3);
    pulse(P_SETM);
    pulse(P_EOD);
    pulse(P_SYM);
    tick;
    chk("R10 first empty", dr_empty, 1'b1);
    pulse(P_END);
    chk("R10 end clears empty", dr_empty, 1'b0);
    pulse(P_TX);
    chk("R11 crc of one byte", {load, tx_byte}, {1'b1, ref_crc(8'hC3, 8'h00, 1'b0)});
    tick;
    chk("R10 no second empty", dr_empty, 1'b0);
    pulse(P_TX);
    pulse(P_SYM);
    chk("R10 response closed", req_m, 1'b0);

    // R13: priority of CRC mode
    settle;
    set_s = 1; set_m = 1; tick; set_s = 0; set_m = 0;
    chk("R13 both set arms crc only", {req_m, req_s}, 2'b10);
    pulse(P_SETS);
    chk("R13 single refused", req_s, 1'b0);
    pulse(P_ERR);
    chk("R12 idle error clears", req_m, 1'b0);

    done = 1;
    summary;
    $finish;
  end
endmodule